// File: doc/BRIEF.md
# Real-time clock interrupt status and control unit

This block collects the interrupt events of a real-time clock and reports them through a small register bank. Three kinds of event arrive from logic outside the block: a one-cycle alarm-match pulse, a vector of periodic tick pulses, and a power-fail level. Each event is captured into a status bit even when its interrupt is masked. Enable bits decide which captured events drive the two interrupt pins. The first pin is an active-low interrupt request. The second is a multi-function output that can carry the power-fail interrupt on its own. A summary bit in the main status register shows whether either pin is currently active, so a processor sharing a wired interrupt line can poll one byte to find out whether this block is the source.

Software reaches the registers over a synchronous bus with a chip select, a page bit, an address, read and write strobes and byte data. Read data is combinational while a read is selected. All state is captured on the rising clock edge. Because the interrupt pins are decoded straight from registered status, a pin changes right after the edge that updates its status.

Top module: `rtc_irq_hub`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0, `irq_n` is 1 and `mfo` is 0.
- R2: The register map decodes as follows. Any unmapped address/page pair reads 0.
  - Address 0 is the main status register on either page.
  - Page 0, address 3 is the tick flag register.
  - Page 1, address 3 is the tick enable register, with bit i enabling tick i.
  - Page 1, address 4 is the event enable register: bit 0 enables the alarm interrupt and bit 1 enables the power-fail interrupt.
  - Page 1, address 2 is the routing register: bit 0 sends the power-fail interrupt to `mfo`.
  - Unimplemented bits of the mapped registers read 0.
- R3: An `alarm_evt` pulse sets status bit 3 whatever the alarm enable is. `irq_n` goes low only while bit 3 is set and the alarm enable is 1.
- R4: Writing 1 to status bit 2 or bit 3 clears that bit. Writing 0 leaves it unchanged. An event arriving in the same cycle as the clearing write keeps the bit set.
- R5: A pulse on `tick_evt[i]` sets bit i of the tick flag register whatever the enables are. Any read or write of that register clears all its flags after the access. A read returns the flags as they were before the clear. A tick arriving in the same cycle as the access survives.
- R6: Status bit 2 is set by a tick whose enable bit is 1. While bit 2 is set, `irq_n` is low, even after every tick enable has been cleared, until bit 2 is cleared by a write.
- R7: Status bit 1 sets only while the power-fail enable is 1, `pfail` is 1 and `cs` is 0. Writes cannot clear it. It clears on the first edge at which `pfail` is 0.
- R8: When routing bit 0 is 0, a set and enabled status bit 1 drives `irq_n` low. When routing bit 0 is 1, it drives `mfo` high instead, and it does not affect `irq_n`.
- R9: Status bit 0 reads 1 exactly when `irq_n` is 0 or `mfo` is 1.
- R10: With every enable bit at 0, neither pin becomes active under any event, while the status bits and tick flags still capture events for polling.
- R11: Status bits 4 to 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for register access |
| page | input | 1 | Page select |
| addr | input | AW (3) | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Read data, 0 when no read is selected |
| alarm_evt | input | 1 | Alarm-match pulse |
| tick_evt | input | NTICK (6) | Periodic tick pulses |
| pfail | input | 1 | Power-fail level |
| irq_n | output | 1 | Active-low interrupt request |
| mfo | output | 1 | Multi-function output that carries the routed power-fail interrupt |

## Verification
Two kinds of function can land on the same clock edge, and the bench drives both on purpose. In the first, a status-clearing write coincides with a new alarm or tick event. In the second, an access to the tick flag register coincides with a new tick. The bench holds the bus strobes and the event pulse over the same edge. A coincidence is judged correct if the later read shows the event captured, not lost to the clear, and if the read made during the colliding access returned the flags as they were before it. A third case holds `cs` high while `pfail` rises, and it is judged by `mfo` staying inactive until the select drops.

// File: rtl/rtc_irq_hub.sv
module rtc_irq_hub #(
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int NTICK = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             page,
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             alarm_evt,
  input  logic [NTICK-1:0] tick_evt,
  input  logic             pfail,
  output logic             irq_n,
  output logic             mfo
);
  localparam logic [AW-1:0] A_STAT  = AW'(0);
  localparam logic [AW-1:0] A_ROUTE = AW'(2);
  localparam logic [AW-1:0] A_TICK  = AW'(3);
  localparam logic [AW-1:0] A_EVEN  = AW'(4);
  localparam int B_PF  = 1;
  localparam int B_PER = 2;
  localparam int B_ALM = 3;

  logic [NTICK-1:0] tick_flag, tick_en;
  logic             alm_ie, pf_ie, route;
  logic             st_pf, st_per, st_alm;

  logic sel_stat, sel_tick, sel_tick_en, sel_even, sel_route;
  assign sel_stat    = cs && addr == A_STAT;
  assign sel_tick    = cs && !page && addr == A_TICK;
  assign sel_tick_en = cs &&  page && addr == A_TICK;
  assign sel_even    = cs &&  page && addr == A_EVEN;
  assign sel_route   = cs &&  page && addr == A_ROUTE;

  logic stat_wr, pf_int, per_hit, pf_irq, any_irq;
  assign stat_wr = sel_stat && wr;
  assign pf_int  = pfail && !cs;
  assign per_hit = |(tick_evt & tick_en);
  assign pf_irq  = st_pf && pf_ie;
  assign any_irq = st_per || (st_alm && alm_ie) || (pf_irq && !route);

  assign irq_n = !any_irq;
  assign mfo   = pf_irq && route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_en <= '0;
      alm_ie  <= 1'b0;
      pf_ie   <= 1'b0;
      route   <= 1'b0;
    end else if (wr) begin
      if (sel_tick_en) tick_en <= wdata[NTICK-1:0];
      if (sel_even)    {pf_ie, alm_ie} <= wdata[1:0];
      if (sel_route)   route <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_flag <= '0;
    else        tick_flag <= ((sel_tick && (rd || wr)) ? '0 : tick_flag) | tick_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_pf  <= 1'b0;
      st_per <= 1'b0;
      st_alm <= 1'b0;
    end else begin
      st_pf  <= (st_pf || (pf_ie && pf_int)) && pfail;
      st_per <= (st_per && !(stat_wr && wdata[B_PER])) || per_hit;
      st_alm <= (st_alm && !(stat_wr && wdata[B_ALM])) || alarm_evt;
    end
  end

  logic [DW-1:0] stat_val;
  always_comb begin
    stat_val        = '0;
    stat_val[0]     = !irq_n || mfo;
    stat_val[B_PF]  = st_pf;
    stat_val[B_PER] = st_per;
    stat_val[B_ALM] = st_alm;
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (sel_stat)         rdata = stat_val;
      else if (sel_tick)    rdata[NTICK-1:0] = tick_flag;
      else if (sel_tick_en) rdata[NTICK-1:0] = tick_en;
      else if (sel_even)    rdata[1:0] = {pf_ie, alm_ie};
      else if (sel_route)   rdata[0] = route;
    end
  end
endmodule

// File: rtl/rtc_irq_hub_chk.sv
module rtc_irq_hub_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          alarm_evt,
  input logic          pfail,
  input logic          pf_ie,
  input logic          irq_n,
  input logic          mfo,
  input logic          st_pf,
  input logic          st_alm
);
  assert_alarm_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> st_alm);

  assert_clear_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == '0 && wdata[3] && !alarm_evt) |=> !st_alm);

  assert_pf_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pfail |=> !st_pf);

  assert_pf_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pf) |-> $past(pfail && !cs && pf_ie));

  assert_mfo_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mfo |-> (st_pf && pf_ie && irq_n == irq_n));

  assert_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == '0) |-> rdata[0] == (!irq_n || mfo));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == '0) |-> rdata[7:4] == 4'h0);
endmodule

bind rtc_irq_hub rtc_irq_hub_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .alarm_evt(alarm_evt), .pfail(pfail),
  .pf_ie(pf_ie), .irq_n(irq_n), .mfo(mfo), .st_pf(st_pf), .st_alm(st_alm)
);

// File: tb/tb_rtc_irq_hub.sv
module tb_rtc_irq_hub;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, page = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       alarm_evt = 0;
  logic [5:0] tick_evt = '0;
  logic       pfail = 0;
  logic       irq_n, mfo;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  rtc_irq_hub dut (.clk(clk), .rst_n(rst_n), .cs(cs), .page(page), .addr(addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .alarm_evt(alarm_evt),
    .tick_evt(tick_evt), .pfail(pfail), .irq_n(irq_n), .mfo(mfo));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic p, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; page = p; addr = a;
    #5 d = rdata;
    @(posedge clk); #1 cs = 0; rd = 0;
  endtask

  task automatic wr_reg(input logic p, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; page = p; addr = a; wdata = d;
    @(posedge clk); #1 cs = 0; wr = 0; wdata = '0;
  endtask

  task automatic tick(input int i);
    @(negedge clk); tick_evt[i] = 1'b1;
    @(posedge clk); #1 tick_evt = '0;
  endtask

  task automatic alarm();
    @(negedge clk); alarm_evt = 1;
    @(posedge clk); #1 alarm_evt = 0;
  endtask

  task automatic expect_pins(input string tag, input logic en_irq, input logic en_mfo);
    chk(tag, {6'b0, irq_n, mfo}, {6'b0, !en_irq, en_mfo});
  endtask

  initial begin
    logic [7:0] d;
    #55 rst_n = 1;
    // R1 reset state, R2 decoding of unmapped locations
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < 8; a++) begin
        rd_reg(p[0], a[2:0], d);
        chk("R1 reset read", d, 8'h00);
      end
    expect_pins("R1 reset pins", 0, 0);

    // R2 readback of control registers and unimplemented bits
    wr_reg(1, 3, 8'hFF); rd_reg(1, 3, d); chk("R2 tick enable", d, 8'h3F);
    wr_reg(1, 3, 8'h2A); rd_reg(1, 3, d); chk("R2 tick enable", d, 8'h2A);
    wr_reg(1, 4, 8'hFE); rd_reg(1, 4, d); chk("R2 event enable", d, 8'h02);
    wr_reg(1, 2, 8'hFF); rd_reg(1, 2, d); chk("R2 routing", d, 8'h01);
    rd_reg(0, 4, d); chk("R2 unmapped p0 a4", d, 8'h00);
    rd_reg(0, 2, d); chk("R2 unmapped p0 a2", d, 8'h00);
    rd_reg(1, 7, d); chk("R2 unmapped p1 a7", d, 8'h00);
    wr_reg(1, 3, 0); wr_reg(1, 4, 0); wr_reg(1, 2, 0);

    // R10 all enables off: events only set status
    alarm(); tick(1);
    expect_pins("R10 pins idle", 0, 0);
    rd_reg(0, 0, d); chk("R10 status polled R11", d, 8'h08);
    rd_reg(0, 3, d); chk("R10 tick flag", d, 8'h02);
    wr_reg(1, 0, 8'h08);
    rd_reg(1, 0, d); chk("R4 clear alarm page1 R2", d, 8'h00);

    // R3 alarm with each enable value, R4 write-0 ignored, R9 summary
    for (int ie = 0; ie < 2; ie++) begin
      wr_reg(1, 4, ie[7:0]);
      alarm();
      expect_pins("R3 alarm pins", ie[0], 0);
      wr_reg(0, 0, 8'hF7);
      rd_reg(0, 0, d); chk("R4 write0 keeps R9", d, {4'h0, 1'b1, 2'b00, ie[0]});
      wr_reg(0, 0, 8'h08);
      expect_pins("R4 cleared pins", 0, 0);
      rd_reg(0, 0, d); chk("R4 cleared", d, 8'h00);
    end

    // R4 collision: alarm on the clearing edge keeps the bit
    @(negedge clk); cs = 1; wr = 1; page = 0; addr = 0; wdata = 8'h08; alarm_evt = 1;
    @(posedge clk); #1 cs = 0; wr = 0; alarm_evt = 0; wdata = 0;
    rd_reg(0, 0, d); chk("R4 alarm vs clear", d, 8'h09);
    wr_reg(0, 0, 8'h08); wr_reg(1, 4, 0);

    // R5/R6 periodic sweep over ticks and enable patterns
    for (int i = 0; i < 6; i++)
      for (int k = 0; k < 4; k++) begin
        logic [5:0] en;
        logic       hit;
        case (k)
          0: en = 6'h00;
          1: en = 6'b1 << i;
          2: en = ~(6'b1 << i);
          default: en = 6'h3F;
        endcase
        hit = en[i];
        wr_reg(1, 3, {2'b0, en});
        tick(i);
        expect_pins("R6 tick pin", hit, 0);
        rd_reg(0, 3, d); chk("R5 flag set", d, {2'b0, 6'b1 << i});
        rd_reg(0, 3, d); chk("R5 flag cleared by read", d, 8'h00);
        rd_reg(1, 0, d); chk("R6 status R9", d, {5'b0, hit, 1'b0, hit});
        wr_reg(1, 3, 0);
        expect_pins("R6 pending held", hit, 0);
        wr_reg(0, 0, 8'h04);
        expect_pins("R6 cleared", 0, 0);
      end

    // R5 write access clears flags
    tick(4); wr_reg(0, 3, 8'h00);
    rd_reg(0, 3, d); chk("R5 cleared by write", d, 8'h00);

    // R5 collision: tick during read of flag register
    @(negedge clk); cs = 1; rd = 1; page = 0; addr = 3; tick_evt = 6'h04;
    #5 d = rdata;
    @(posedge clk); #1 cs = 0; rd = 0; tick_evt = 0;
    chk("R5 pre-clear read", d, 8'h00);
    rd_reg(0, 3, d); chk("R5 tick survives", d, 8'h04);

    // R4 collision: enabled tick on D2 clearing edge
    wr_reg(1, 3, 8'h01);
    tick(0);
    @(negedge clk); cs = 1; wr = 1; page = 0; addr = 0; wdata = 8'h04; tick_evt = 6'h01;
    @(posedge clk); #1 cs = 0; wr = 0; tick_evt = 0; wdata = 0;
    expect_pins("R4 tick vs clear", 1, 0);
    wr_reg(0, 0, 8'h04); wr_reg(1, 3, 0);
    rd_reg(0, 3, d);

    // R7/R8 power fail over enable and routing
    for (int r = 0; r < 2; r++)
      for (int ie = 0; ie < 2; ie++) begin
        logic act;
        act = ie[0];
        wr_reg(1, 2, r[7:0]);
        wr_reg(1, 4, {6'b0, ie[0], 1'b0});
        @(negedge clk); pfail = 1;
        @(posedge clk); #1;
        expect_pins("R8 pfail pins", act && !r[0], act && r[0]);
        wr_reg(0, 0, 8'hFF);
        rd_reg(0, 0, d); chk("R7 no write clear R9", d, {6'b0, act, act});
        @(negedge clk); pfail = 0;
        @(posedge clk); #1;
        expect_pins("R7 cleared on drop", 0, 0);
        rd_reg(0, 0, d); chk("R7 status cleared", d, 8'h00);
      end

    // R7 gating by chip select
    wr_reg(1, 2, 1); wr_reg(1, 4, 2);
    @(negedge clk); cs = 1; rd = 1; page = 1; addr = 7; pfail = 1;
    repeat (3) @(posedge clk);
    #1 chk("R7 gated while selected", {7'b0, mfo}, 8'h00);
    @(negedge clk); cs = 0; rd = 0;
    @(posedge clk); #1 chk("R7 sets after release", {7'b0, mfo}, 8'h01);
    @(negedge clk); pfail = 0;
    @(posedge clk); #1 expect_pins("R7 final drop", 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule